// File: doc/BRIEF.md
# Strip Iteration Sequencer for Vector and Matrix Instructions

This block steps one vector or matrix instruction through a datapath of four parallel lanes. When an instruction starts, the sequencer captures three loop bounds: how many strips there are, how many elements each strip holds, and, for multiply-accumulate matrix products only, an inner dimension. It then produces one operation group per clock cycle. Each group carries a set of lane enables, the element indices of both sources and of the destination in the matrix register file, and a flag that tells the lanes to accumulate into the destination rather than overwrite it.

The matrix register file holds 16 registers, and each register is a 4x4 block of 16 elements. An element index is the register number times 16 plus the element offset, taken modulo 256. In element-wise mode all three operands walk the same offsets: strip `i` covers offsets `i*width` and onward, in groups of four. In matrix-product mode, lane `l` of step `(i, g, k)` computes `C[i][4g+l] += A[i][k] * B[k][4g+l]`. A is indexed row by row with the inner dimension as its row length. B and C use the strip width as their row length. The arithmetic and the register storage sit outside this block.

The instruction issuer pulses `start` with the bounds valid. It then watches `busy` and `done` to learn when the lanes are free.

Top module: `strip_seq`

## Requirements
- R1: After reset, `busy`, `done`, `accumulate` and `lane_en` are all 0.
- R2: In element-wise mode (`op_mmul`=0) with nonzero strip count S and width W, `busy` rises on the edge that samples `start`. It stays high for exactly S*ceil(W/4) cycles, one group per cycle. On the cycle after the last group, `done` is 1 and `busy` is 0.
- R3: In element-wise mode, group `g` of strip `i` has offset `i*W + 4g`. Each index equals its own register number times 16 plus that offset, modulo 256, for the destination and for both sources.
- R4: Lane `l` (bit `l` of `lane_en`) is enabled during group `g` exactly when `4g + l < W`. So lanes beyond a width under four stay off. `lane_en` is 0 whenever `busy` is 0.
- R5: In matrix-product mode (`op_mmul`=1) with nonzero S, W and D, the run lasts S*ceil(W/4)*D cycles. The strip loop is outermost, the column-group loop is in the middle and the dimension loop is innermost.
- R6: In matrix-product mode at step `(i, g, k)`: `dst_idx` = 16*dst_reg + i*W + 4g; `src_a_idx` = 16*src_a_reg + i*D + k; `src_b_idx` = 16*src_b_reg + k*W + 4g. All three are taken modulo 256.
- R7: `accumulate` is 1 exactly on matrix-product steps with k != 0, and is 0 in element-wise mode.
- R8: A start with zero in any bound that the mode uses gives `done`=1 on the next cycle, and `busy` never rises. The bounds used are S and W in element-wise mode, and S, W and D in matrix-product mode. In element-wise mode D is ignored, even when it is zero.
- R9: A `start` that arrives while `busy` is 1 is ignored. The running sequence continues unchanged.
- R10: The bounds, the mode and the register numbers are captured on the accepted start. Later changes on those inputs do not alter the running sequence.
- R11: `done` is a single-cycle pulse for each instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an instruction (accepted when not busy) |
| op_mmul | input | 1 | 0 = element-wise, 1 = matrix product |
| strip_cnt | input | 3 | Number of strips S |
| strip_width | input | 3 | Elements per strip W |
| dim_cnt | input | 3 | Inner dimension D (matrix product only) |
| dst_reg | input | 4 | Destination matrix register number |
| src_a_reg | input | 4 | First source matrix register number |
| src_b_reg | input | 4 | Second source matrix register number |
| busy | output | 1 | A group is being issued this cycle |
| done | output | 1 | One-cycle completion pulse |
| lane_en | output | 4 | Per-lane enables of the current group |
| accumulate | output | 1 | Lanes accumulate into the destination |
| dst_idx | output | 8 | Destination element index |
| src_a_idx | output | 8 | First source element index |
| src_b_idx | output | 8 | Second source element index |

## Verification
The first group is visible on the outputs one cycle after the edge that samples `start`. Each later group follows one cycle after the one before it. `done` appears one cycle after the last group, or one cycle after the start when a bound is zero. The bench drives inputs on falling edges and samples on falling edges. This puts the first sample half a cycle after the capture edge, and each later sample one full cycle after the one before it. The expected group for that cycle comes from its own nested loops. The bench sweeps every combination of S in 0..3, W in 0..6 and D in 0..3 in both modes. In every run it holds `start` high with scrambled bounds during the first group, to exercise the ignore and capture rules.

// File: rtl/strip_seq_pkg.sv
package strip_seq_pkg;
  typedef enum logic {
    OP_ELEM = 1'b0,
    OP_MMUL = 1'b1
  } op_class_e;
endpackage

// File: rtl/strip_loop_ctr.sv
module strip_loop_ctr #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          adv,
  input  logic [CW-1:0] limit,
  output logic [CW-1:0] count,
  output logic          last
);
  logic [CW-1:0] cnt_q, cnt_d;

  assign last  = (cnt_q == (limit - CW'(1)));
  assign count = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)
      cnt_d = '0;
    else if (adv)
      cnt_d = last ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (clr || adv)
      cnt_q <= cnt_d;
  end

  // R5
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> (cnt_q < limit));
endmodule

// File: rtl/strip_lane_mask.sv
module strip_lane_mask #(
  parameter int LANES = 4,
  parameter int CW    = 3
) (
  input  logic [CW-1:0]    width,
  input  logic [CW-1:0]    grp,
  output logic [LANES-1:0] mask
);
  localparam int MW = CW + $clog2(LANES) + 1;

  logic [MW-1:0] grp_base;
  assign grp_base = MW'(grp) * MW'(LANES);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign mask[l] = (grp_base + MW'(l)) < MW'(width);
  end
endmodule

// File: rtl/strip_index_gen.sv
module strip_index_gen #(
  parameter int LANES = 4,
  parameter int CW    = 3,
  parameter int RW    = 4,
  parameter int ESH   = 4,
  parameter int IW    = RW + ESH
) (
  input  logic          mmul,
  input  logic [CW-1:0] row,
  input  logic [CW-1:0] grp,
  input  logic [CW-1:0] kk,
  input  logic [CW-1:0] width,
  input  logic [CW-1:0] dim,
  input  logic [RW-1:0] dst_reg,
  input  logic [RW-1:0] a_reg,
  input  logic [RW-1:0] b_reg,
  output logic [IW-1:0] dst_idx,
  output logic [IW-1:0] a_idx,
  output logic [IW-1:0] b_idx
);
  logic [IW-1:0] col_off, ew_off, a_off, b_off;

  always_comb begin
    col_off = IW'(grp) * IW'(LANES);
    ew_off  = IW'(row) * IW'(width) + col_off;
    if (mmul) begin
      a_off = IW'(row) * IW'(dim) + IW'(kk);
      b_off = IW'(kk) * IW'(width) + col_off;
    end else begin
      a_off = ew_off;
      b_off = ew_off;
    end
    dst_idx = {dst_reg, {ESH{1'b0}}} + ew_off;
    a_idx   = {a_reg, {ESH{1'b0}}} + a_off;
    b_idx   = {b_reg, {ESH{1'b0}}} + b_off;
  end
endmodule

// File: rtl/strip_seq.sv
module strip_seq #(
  parameter int LANES = 4,
  parameter int CW    = 3,
  parameter int RW    = 4,
  parameter int ELEMS = 16,
  parameter int ESH   = $clog2(ELEMS),
  parameter int IW    = RW + ESH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             op_mmul,
  input  logic [CW-1:0]    strip_cnt,
  input  logic [CW-1:0]    strip_width,
  input  logic [CW-1:0]    dim_cnt,
  input  logic [RW-1:0]    dst_reg,
  input  logic [RW-1:0]    src_a_reg,
  input  logic [RW-1:0]    src_b_reg,
  output logic             busy,
  output logic             done,
  output logic [LANES-1:0] lane_en,
  output logic             accumulate,
  output logic [IW-1:0]    dst_idx,
  output logic [IW-1:0]    src_a_idx,
  output logic [IW-1:0]    src_b_idx
);
  import strip_seq_pkg::*;

  op_class_e     cls_q;
  logic [CW-1:0] s_q, w_q, d_q;
  logic [RW-1:0] dr_q, ar_q, br_q;
  logic          busy_q, busy_d, done_q, done_d;

  logic          accept, zero_cfg;
  logic [CW:0]   w_round;
  logic [CW-1:0] grp_lim, k_lim;
  logic [CW-1:0] i_cnt, g_cnt, k_cnt;
  logic          i_last, g_last, k_last, step_last;
  logic [LANES-1:0] mask;

  assign accept   = start && !busy_q;
  assign zero_cfg = (strip_cnt == '0) || (strip_width == '0) ||
                    (op_mmul && (dim_cnt == '0));

  assign w_round = {1'b0, w_q} + (CW+1)'(LANES - 1);
  assign grp_lim = CW'(w_round / (CW+1)'(LANES));
  assign k_lim   = (cls_q == OP_MMUL) ? d_q : CW'(1);

  strip_loop_ctr #(.CW(CW)) i_k_ctr (
    .clk(clk), .rst_n(rst_n), .clr(accept), .adv(busy_q),
    .limit(k_lim), .count(k_cnt), .last(k_last));

  strip_loop_ctr #(.CW(CW)) i_g_ctr (
    .clk(clk), .rst_n(rst_n), .clr(accept), .adv(busy_q && k_last),
    .limit(grp_lim), .count(g_cnt), .last(g_last));

  strip_loop_ctr #(.CW(CW)) i_i_ctr (
    .clk(clk), .rst_n(rst_n), .clr(accept), .adv(busy_q && k_last && g_last),
    .limit(s_q), .count(i_cnt), .last(i_last));

  assign step_last = k_last && g_last && i_last;

  strip_lane_mask #(.LANES(LANES), .CW(CW)) i_mask (
    .width(w_q), .grp(g_cnt), .mask(mask));

  strip_index_gen #(.LANES(LANES), .CW(CW), .RW(RW), .ESH(ESH), .IW(IW)) i_idx (
    .mmul(cls_q == OP_MMUL), .row(i_cnt), .grp(g_cnt), .kk(k_cnt),
    .width(w_q), .dim(d_q), .dst_reg(dr_q), .a_reg(ar_q), .b_reg(br_q),
    .dst_idx(dst_idx), .a_idx(src_a_idx), .b_idx(src_b_idx));

  always_comb begin
    busy_d = busy_q;
    if (accept && !zero_cfg)
      busy_d = 1'b1;
    else if (busy_q && step_last)
      busy_d = 1'b0;
    done_d = (accept && zero_cfg) || (busy_q && step_last);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cls_q <= OP_ELEM;
      s_q   <= '0;
      w_q   <= '0;
      d_q   <= '0;
      dr_q  <= '0;
      ar_q  <= '0;
      br_q  <= '0;
    end else if (accept) begin
      cls_q <= op_mmul ? OP_MMUL : OP_ELEM;
      s_q   <= strip_cnt;
      w_q   <= strip_width;
      d_q   <= dim_cnt;
      dr_q  <= dst_reg;
      ar_q  <= src_a_reg;
      br_q  <= src_b_reg;
    end
  end

  assign busy       = busy_q;
  assign done       = done_q;
  assign lane_en    = busy_q ? mask : '0;
  assign accumulate = busy_q && (cls_q == OP_MMUL) && (k_cnt != '0);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !done);

  // R2
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  // R4
  lane_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (lane_en == '0));

  // R4
  lane_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> lane_en[0]);

  // R7
  acc_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accumulate |-> busy);

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(s_q) && $stable(w_q) && $stable(d_q) && $stable(cls_q)));
endmodule

// File: tb/test_strip_seq.sv
module test_strip_seq;
  logic       clk, rst_n, start, op_mmul;
  logic [2:0] strip_cnt, strip_width, dim_cnt;
  logic [3:0] dst_reg, src_a_reg, src_b_reg;
  logic       busy, done, accumulate;
  logic [3:0] lane_en;
  logic [7:0] dst_idx, src_a_idx, src_b_idx;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  strip_seq i_strip_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .op_mmul(op_mmul),
    .strip_cnt(strip_cnt), .strip_width(strip_width), .dim_cnt(dim_cnt),
    .dst_reg(dst_reg), .src_a_reg(src_a_reg), .src_b_reg(src_b_reg),
    .busy(busy), .done(done), .lane_en(lane_en), .accumulate(accumulate),
    .dst_idx(dst_idx), .src_a_idx(src_a_idx), .src_b_idx(src_b_idx));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run(input bit mm, input int s, input int w, input int d,
                     input int db, input int ab, input int bb);
    bit zero;
    bit first;
    int gl, kl, off, ea, eb, ed, el;
    zero = (s == 0) || (w == 0) || (mm && d == 0);
    @(negedge clk);
    op_mmul = mm; strip_cnt = 3'(s); strip_width = 3'(w); dim_cnt = 3'(d);
    dst_reg = 4'(db); src_a_reg = 4'(ab); src_b_reg = 4'(bb);
    start = 1'b1;
    if (zero) begin
      @(negedge clk);
      start = 1'b0;
      chk("R8 done after zero bound", done, 1);
      chk("R8 busy stays low", busy, 0);
      @(negedge clk);
      chk("R11 done single pulse", done, 0);
      return;
    end
    gl = (w + 3) / 4;
    kl = mm ? d : 1;
    first = 1;
    for (int i = 0; i < s; i++)
      for (int g = 0; g < gl; g++)
        for (int k = 0; k < kl; k++) begin
          @(negedge clk);
          chk(mm ? "R5 busy during step" : "R2 busy during step", busy, 1);
          el = 0;
          for (int l = 0; l < 4; l++)
            if (4*g + l < w) el |= (1 << l);
          chk("R4 lane enables", lane_en, el);
          off = i*w + 4*g;
          ed = (db*16 + off) & 255;
          ea = (ab*16 + (mm ? i*d + k : off)) & 255;
          eb = (bb*16 + (mm ? k*w + 4*g : off)) & 255;
          // R9 and R10: values stay those captured despite later inputs
          chk(mm ? "R6 dst index" : "R3 dst index", dst_idx, ed);
          chk(mm ? "R6 src_a index" : "R3 src_a index", src_a_idx, ea);
          chk(mm ? "R6 src_b index" : "R3 src_b index", src_b_idx, eb);
          chk("R7 accumulate", accumulate, (mm && k != 0) ? 1 : 0);
          if (first) begin
            first = 0;
            op_mmul = ~mm; strip_cnt = ~strip_cnt; strip_width = ~strip_width;
            dim_cnt = ~dim_cnt; dst_reg = ~dst_reg; src_a_reg = ~src_a_reg;
            src_b_reg = ~src_b_reg;
          end else begin
            start = 1'b0;
          end
        end
    @(negedge clk);
    start = 1'b0;
    chk(mm ? "R5 done after last step" : "R2 done after last step", done, 1);
    chk("R2 busy low at done", busy, 0);
    chk("R4 lanes idle", lane_en, 0);
    @(negedge clk);
    chk("R11 done single pulse", done, 0);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; op_mmul = 1'b0;
    strip_cnt = '0; strip_width = '0; dim_cnt = '0;
    dst_reg = '0; src_a_reg = '0; src_b_reg = '0;
    repeat (3) @(negedge clk);
    chk("R1 busy after reset", busy, 0);
    chk("R1 done after reset", done, 0);
    chk("R1 lane_en after reset", lane_en, 0);
    chk("R1 accumulate after reset", accumulate, 0);
    rst_n = 1'b1;
    for (int mm = 0; mm < 2; mm++)
      for (int s = 0; s < 4; s++)
        for (int w = 0; w < 7; w++)
          for (int d = 0; d < 4; d++)
            run(mm[0], s, w, d, (s*3 + w) & 15, (w*5 + d + 7) & 15, (d*11 + s + 13) & 15);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule